// File: doc/BRIEF.md
# Big-endian sub-word load/store aligner

This block sits between the register file and a 32-bit data bus. It moves word, half-word and byte quantities onto and off the bus lanes. On a store it copies the low half-word or low byte of the source register onto every lane that could hold it. It then produces per-lane byte enables, so the enables alone pick the lanes the memory writes. On a load it takes the returned bus word and picks out the addressed byte or half-word. It then widens that value to 32 bits, with sign or zero fill as the opcode selects. Lanes are numbered big-endian: the lowest byte offset is the most significant byte of the bus word.

Each transaction is a set of inputs: a 6-bit opcode, the low byte-offset bits of an already aligned address, the source register and the bus read word. It enters on a valid/ready handshake and leaves from a single output register on a second valid/ready handshake. An input is accepted when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register and every output field hold their values. Address generation, fault detection and the bus protocol itself belong to the surrounding logic.

Top module: `lsalign_unit`

## Requirements
- R1: Opcode 110101 (word store) gives `out_wdata` equal to the source register and `out_be` = 1111.
- R2: Opcode 110110 (half-word store) puts source bits 15..0 on both bits 31..16 and bits 15..0 of `out_wdata`. `out_be` is 1100 for offset 0 and 0011 for offset 2, where `out_be` bit 3 is lane 31..24.
- R3: Opcode 110111 (byte store) repeats source bits 7..0 in all four lanes. `out_be` is one-hot with bit (3 - offset) set, so offset 0 selects bits 31..24 and offset 3 selects bits 7..0.
- R4: Opcode 110000 (word load) returns the bus word unchanged on `out_rdata`.
- R5: Opcode 110001 (signed half-word load) takes bits 31..16 at offset 0 and bits 15..0 at offset 2, then sign-extends the result to 32 bits.
- R6: Opcode 110010 (unsigned half-word load) selects the same half-word as R5 and zero-extends it.
- R7: Opcode 110011 (signed byte load) takes bus bits (31-8k)..(24-8k) at offset k, then sign-extends the result.
- R8: Opcode 110100 (unsigned byte load) selects the same byte as R7 and zero-extends it.
- R9: A load sets `out_is_load`, drives `out_be` = 0000 and `out_wdata` = 0. A store sets `out_is_store` and drives `out_rdata` = 0. Any other opcode gives all of these outputs zero.
- R10: An input is taken when `in_valid` and `in_ready` are both high, and its result appears on the outputs one clock later with `out_valid` high. `in_ready` equals `out_ready` OR NOT `out_valid`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R11: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_opcode | input | 6 | Load/store opcode |
| in_offset | input | 2 | Byte offset within the bus word (aligned) |
| in_reg | input | 32 | Source register value for stores |
| in_rdword | input | 32 | Word returned by the bus for loads |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_is_load | output | 1 | Result belongs to a load opcode |
| out_is_store | output | 1 | Result belongs to a store opcode |
| out_wdata | output | 32 | Lane-placed store data |
| out_be | output | 4 | Store byte enables, bit 3 = bits 31..24 |
| out_rdata | output | 32 | Extended load result |

## Verification
All eight opcodes are driven at every aligned offset. The data patterns use sign bits set in some lanes and clear in others, for example 80FF7F01 and 7F00807F. With these patterns a swapped lane order, a wrong half-word choice, or sign fill confused with zero fill each gives a visibly different result. Opcodes outside the load/store group are driven to confirm that all outputs stay zero. A long random phase then combines random opcodes, offsets and data with random `in_valid` and `out_ready`. Together these cover acceptance, draining and the hold of stalled outputs.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD_WORD  = 6'b110000;
  localparam logic [OPC_W-1:0] OPC_LD_HALFS = 6'b110001;
  localparam logic [OPC_W-1:0] OPC_LD_HALFU = 6'b110010;
  localparam logic [OPC_W-1:0] OPC_LD_BYTES = 6'b110011;
  localparam logic [OPC_W-1:0] OPC_LD_BYTEU = 6'b110100;
  localparam logic [OPC_W-1:0] OPC_ST_WORD  = 6'b110101;
  localparam logic [OPC_W-1:0] OPC_ST_HALF  = 6'b110110;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE  = 6'b110111;

  // transfer width selected by the opcode
  typedef enum logic [1:0] {
    XS_NONE = 2'd0,
    XS_BYTE = 2'd1,
    XS_HALF = 2'd2,
    XS_WORD = 2'd3
  } xsize_e;

  typedef struct packed {
    logic   is_load;
    logic   is_store;
    logic   sext;
    xsize_e size;
  } ls_ctrl_t;

endpackage

// File: rtl/lsalign_decode.sv
module lsalign_decode
  import lsalign_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ls_ctrl_t         ctrl
);

  always_comb begin
    ctrl = '{is_load: 1'b0, is_store: 1'b0, sext: 1'b0, size: XS_NONE};
    unique case (opcode)
      OPC_LD_WORD:  ctrl = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, size: XS_WORD};
      OPC_LD_HALFS: ctrl = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b1, size: XS_HALF};
      OPC_LD_HALFU: ctrl = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, size: XS_HALF};
      OPC_LD_BYTES: ctrl = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b1, size: XS_BYTE};
      OPC_LD_BYTEU: ctrl = '{is_load: 1'b1, is_store: 1'b0, sext: 1'b0, size: XS_BYTE};
      OPC_ST_WORD:  ctrl = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, size: XS_WORD};
      OPC_ST_HALF:  ctrl = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, size: XS_HALF};
      OPC_ST_BYTE:  ctrl = '{is_load: 1'b0, is_store: 1'b1, sext: 1'b0, size: XS_BYTE};
      default:      ctrl = '{is_load: 1'b0, is_store: 1'b0, sext: 1'b0, size: XS_NONE};
    endcase
  end

endmodule

// File: rtl/lsalign_store_lanes.sv
module lsalign_store_lanes
  import lsalign_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  xsize_e              size,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   wdata,
  output logic [LANES-1:0]    be
);

  // Lane i is byte offset i; it occupies the i-th byte counted from the MSB
  // and owns enable bit LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(i);

    logic [7:0] word_byte;
    logic [7:0] half_byte;
    logic [7:0] byte_byte;
    logic       half_hit;
    logic       byte_hit;

    assign word_byte = src[DATA_W-1-8*i -: 8];
    // even offsets carry the upper byte of the half-word
    assign half_byte = (i % 2 == 0) ? src[15:8] : src[7:0];
    assign byte_byte = src[7:0];

    assign half_hit = (offset[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
    assign byte_hit = (offset == LANE_OFF);

    assign wdata[DATA_W-1-8*i -: 8] =
        (size == XS_WORD) ? word_byte :
        (size == XS_HALF) ? half_byte :
        (size == XS_BYTE) ? byte_byte : 8'h00;

    assign be[LANES-1-i] =
        (size == XS_WORD) ||
        ((size == XS_HALF) && half_hit) ||
        ((size == XS_BYTE) && byte_hit);
  end

endmodule

// File: rtl/lsalign_load_extract.sv
module lsalign_load_extract
  import lsalign_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  xsize_e              size,
  input  logic                sext,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   word,
  output logic [DATA_W-1:0]   result
);

  logic [7:0]  lane_b [LANES];
  logic [15:0] half_h [HALVES];
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign lane_b[i] = word[DATA_W-1-8*i -: 8];
  end

  for (genvar k = 0; k < HALVES; k++) begin : g_half
    assign half_h[k] = {lane_b[2*k], lane_b[2*k+1]};
  end

  assign byte_sel = lane_b[offset];
  assign half_sel = half_h[offset[OFF_W-1:1]];

  always_comb begin
    unique case (size)
      XS_WORD: result = word;
      XS_HALF: result = {{(DATA_W-16){sext & half_sel[15]}}, half_sel};
      XS_BYTE: result = {{(DATA_W-8){sext & byte_sel[7]}}, byte_sel};
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/lsalign_unit.sv
module lsalign_unit
  import lsalign_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPC_W-1:0]    in_opcode,
  input  logic [OFF_W-1:0]    in_offset,
  input  logic [DATA_W-1:0]   in_reg,
  input  logic [DATA_W-1:0]   in_rdword,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_is_load,
  output logic                out_is_store,
  output logic [DATA_W-1:0]   out_wdata,
  output logic [LANES-1:0]    out_be,
  output logic [DATA_W-1:0]   out_rdata
);

  ls_ctrl_t            ctrl;
  xsize_e              st_size;
  xsize_e              ld_size;
  logic [DATA_W-1:0]   nxt_wdata;
  logic [LANES-1:0]    nxt_be;
  logic [DATA_W-1:0]   nxt_rdata;
  logic                take;

  lsalign_decode u_dec (
    .opcode (in_opcode),
    .ctrl   (ctrl)
  );

  assign st_size = ctrl.is_store ? ctrl.size : XS_NONE;
  assign ld_size = ctrl.is_load  ? ctrl.size : XS_NONE;

  lsalign_store_lanes #(.DATA_W(DATA_W)) u_st (
    .size   (st_size),
    .offset (in_offset),
    .src    (in_reg),
    .wdata  (nxt_wdata),
    .be     (nxt_be)
  );

  lsalign_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size   (ld_size),
    .sext   (ctrl.sext),
    .offset (in_offset),
    .word   (in_rdword),
    .result (nxt_rdata)
  );

  assign in_ready = out_ready || !out_valid;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_is_load  <= 1'b0;
      out_is_store <= 1'b0;
      out_wdata    <= '0;
      out_be       <= '0;
      out_rdata    <= '0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_is_load  <= ctrl.is_load;
      out_is_store <= ctrl.is_store;
      out_wdata    <= nxt_wdata;
      out_be       <= nxt_be;
      out_rdata    <= nxt_rdata;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/lsalign_chk.sv
module lsalign_chk
  import lsalign_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [OPC_W-1:0]    in_opcode,
  input logic [OFF_W-1:0]    in_offset,
  input logic [DATA_W-1:0]   in_reg,
  input logic [DATA_W-1:0]   in_rdword,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_is_load,
  input logic                out_is_store,
  input logic [DATA_W-1:0]   out_wdata,
  input logic [LANES-1:0]    out_be,
  input logic [DATA_W-1:0]   out_rdata
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R11
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_wdata) && $stable(out_be)
      && $stable(out_rdata) && $stable(out_is_load) && $stable(out_is_store)));

  // R9
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_load) |-> (out_be == '0 && out_wdata == '0));

  // R9
  store_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_store) |-> (out_rdata == '0));

  // R1
  word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_ST_WORD) |=>
      (out_valid && out_is_store && (&out_be) && out_wdata == $past(in_reg)));

  // R4
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_LD_WORD) |=>
      (out_valid && out_is_load && out_rdata == $past(in_rdword)));

  // R3
  byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_ST_BYTE) |=> ($countones(out_be) == 1));

  // R8
  ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_opcode == OPC_LD_BYTEU) |=> (out_rdata[DATA_W-1:8] == '0));

endmodule

bind lsalign_unit lsalign_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_opcode    (in_opcode),
  .in_offset    (in_offset),
  .in_reg       (in_reg),
  .in_rdword    (in_rdword),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_is_load  (out_is_load),
  .out_is_store (out_is_store),
  .out_wdata    (out_wdata),
  .out_be       (out_be),
  .out_rdata    (out_rdata)
);

// File: tb/lsalign_unit_test.sv
module lsalign_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [1:0]  in_offset = '0;
  logic [31:0] in_reg = '0;
  logic [31:0] in_rdword = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_load;
  logic        out_is_store;
  logic [31:0] out_wdata;
  logic [3:0]  out_be;
  logic [31:0] out_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lsalign_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_offset(in_offset), .in_reg(in_reg),
    .in_rdword(in_rdword), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_load(out_is_load), .out_is_store(out_is_store),
    .out_wdata(out_wdata), .out_be(out_be), .out_rdata(out_rdata)
  );

  typedef struct packed {
    logic        ld;
    logic        st;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] rdata;
  } exp_t;

  // behavioural reference from the requirements
  function automatic exp_t ref_model(logic [5:0] op, logic [1:0] off,
                                     logic [31:0] r, logic [31:0] w);
    exp_t e;
    int o;
    logic [31:0] t;
    logic [7:0] b;
    logic [15:0] h;
    e = '0;
    o = int'(off);
    t = w >> (8 * (3 - o));
    b = t[7:0];
    t = w >> (8 * (2 - o));
    h = t[15:0];
    case (op)
      6'b110000: begin e.ld = 1; e.rdata = w; end
      6'b110001: begin e.ld = 1; e.rdata = {{16{h[15]}}, h}; end
      6'b110010: begin e.ld = 1; e.rdata = {16'h0, h}; end
      6'b110011: begin e.ld = 1; e.rdata = {{24{b[7]}}, b}; end
      6'b110100: begin e.ld = 1; e.rdata = {24'h0, b}; end
      6'b110101: begin e.st = 1; e.wdata = r; e.be = 4'b1111; end
      6'b110110: begin e.st = 1; e.wdata = {r[15:0], r[15:0]};
                       e.be = (o < 2) ? 4'b1100 : 4'b0011; end
      6'b110111: begin e.st = 1; e.wdata = {4{r[7:0]}}; e.be = 4'b1000 >> o; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_of(logic [5:0] op);
    case (op)
      6'b110101: return "R1";
      6'b110110: return "R2";
      6'b110111: return "R3";
      6'b110000: return "R4";
      6'b110001: return "R5";
      6'b110010: return "R6";
      6'b110011: return "R7";
      6'b110100: return "R8";
      default:   return "R9";
    endcase
  endfunction

  // cycle model of the output register
  logic       m_valid;
  logic [5:0] m_op;
  exp_t       m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_op    <= '0;
      m_exp   <= '0;
    end else if (in_valid && (out_ready || !m_valid)) begin
      m_valid <= 1'b1;
      m_op    <= in_opcode;
      m_exp   <= ref_model(in_opcode, in_offset, in_reg, in_rdword);
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic compare();
    logic exp_rdy;
    string hs;
    exp_rdy = out_ready || !m_valid;
    hs = rst_n ? "R10" : "R11";
    vectors++;
    if (out_valid !== m_valid || in_ready !== exp_rdy) begin
      miscompares++;
      $display("FAIL %s handshake: out_valid=%0b in_ready=%0b expected out_valid=%0b in_ready=%0b",
               hs, out_valid, in_ready, m_valid, exp_rdy);
    end else if (m_valid) begin
      if (out_is_load !== m_exp.ld || out_is_store !== m_exp.st ||
          out_wdata !== m_exp.wdata || out_be !== m_exp.be || out_rdata !== m_exp.rdata) begin
        miscompares++;
        $display("FAIL %s op=%b: ld=%0b st=%0b wdata=%h be=%b rdata=%h expected ld=%0b st=%0b wdata=%h be=%b rdata=%h",
                 tag_of(m_op), m_op, out_is_load, out_is_store, out_wdata, out_be, out_rdata,
                 m_exp.ld, m_exp.st, m_exp.wdata, m_exp.be, m_exp.rdata);
      end
    end
  endtask

  task automatic step(logic v, logic [5:0] op, logic [1:0] off,
                      logic [31:0] r, logic [31:0] w, logic rdy);
    @(negedge clk);
    in_valid  = v;
    in_opcode = op;
    in_offset = off;
    in_reg    = r;
    in_rdword = w;
    out_ready = rdy;
    #1;
    compare();
  endtask

  function automatic logic [1:0] align(logic [5:0] op, logic [1:0] off);
    case (op)
      6'b110000, 6'b110101: return 2'd0;
      6'b110001, 6'b110010, 6'b110110: return {off[1], 1'b0};
      default: return off;
    endcase
  endfunction

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h80FF7F01;
    pats[1] = 32'h7F00807F;
    pats[2] = 32'h12345678;
    pats[3] = 32'hFFFFFFFF;

    // R11: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 6'b110000, 2'd0, 32'h1, 32'h2, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed sweep: every opcode, every aligned offset, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int op = 6'b110000; op <= 6'b110111; op++) begin
        for (int off = 0; off < 4; off++) begin
          if (align(6'(op), 2'(off)) == 2'(off))
            step(1'b1, 6'(op), 2'(off), pats[p] ^ 32'h0000FF00, pats[p], 1'b1);
        end
      end
    end

    // R9: opcodes outside the group
    step(1'b1, 6'b000000, 2'd1, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);
    step(1'b1, 6'b111000, 2'd2, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);
    step(1'b1, 6'b101111, 2'd3, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);
    step(1'b1, 6'b111111, 2'd0, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1);

    // R10: stall with output held, then release
    step(1'b1, 6'b110011, 2'd1, 32'h0, 32'h00800000, 1'b0);
    step(1'b1, 6'b110101, 2'd0, 32'h11111111, 32'h0, 1'b0);
    step(1'b1, 6'b110101, 2'd0, 32'h22222222, 32'h0, 1'b0);
    step(1'b0, 6'b000000, 2'd0, 32'h0, 32'h0, 1'b1);
    step(1'b0, 6'b000000, 2'd0, 32'h0, 32'h0, 1'b1);

    // random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] op;
      logic [1:0] off;
      op  = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'(6'b110000 + $urandom_range(0, 7));
      off = align(op, 2'($urandom));
      step($urandom_range(0, 3) != 0, op, off, $urandom, $urandom, $urandom_range(0, 2) != 0);
    end

    for (int i = 0; i < 3; i++) step(1'b0, 6'b0, 2'd0, 32'h0, 32'h0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule